// File: doc/BRIEF.md
# Test Access Port with Configuration Load and Start-Up Stepping

This block is a test access port controller for a programmable logic device. It has the usual sixteen-state controller and an instruction register. It also carries two instructions of its own for bringing up the device through the serial test pins.

The first of these, the load instruction, takes every TDI bit shifted in during Shift-DR as bitstream data. It packs those bits, most significant bit first, into 32-bit words and hands each finished word to the internal configuration bus with a one-cycle strobe. The second, the start instruction, turns every TCK cycle spent in Shift-DR into one step of the device start-up sequence, through a clock-enable output.

A typical bring-up follows these steps:
1. Load the load instruction.
2. Enter Shift-DR and shift the whole bitstream.
3. Return to Run-Test-Idle.
4. Load the start instruction.
5. Enter Shift-DR and clock as many start-up steps as are needed.
6. Return to Run-Test-Idle.

Three mode pins are decoded into a flag that reports whether boundary-scan configuration was selected. The test port itself works whatever the mode pins hold.

Top module: `cfg_tap_port`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on rising TCK. TRST_n low forces Test-Logic-Reset at once. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state.
- R2: The instruction register is 5 bits, shifted least significant bit first. It captures 5'b00001 in Capture-IR and updates from the shift stage on the edge that leaves Update-IR. It holds 5'b01001 (IDCODE) after reset or Test-Logic-Reset. The opcodes are BYPASS 5'b11111, IDCODE 5'b01001, load 5'b00101 and start 5'b01100.
- R3: Under IDCODE, Capture-DR loads the 32-bit identification value (default 32'h1A5C_E093). Shift-DR then moves it out on TDO, least significant bit first.
- R4: Under every instruction other than IDCODE, the data path is a one-bit register. It captures 0 and delays TDI by one TCK.
- R5: Under the load instruction in Shift-DR, bits are packed most significant bit first. After the rising edge that shifts the 32nd bit of a word, the word appears on cfg_word and cfg_word_valid is high for exactly one TCK.
- R6: Each Capture-DR restarts the bit count. Bits of a word left incomplete at the end of a shift are discarded, and the next shift starts a fresh word.
- R7: No word strobe is produced in Shift-DR under BYPASS or the start instruction.
- R8: startup_ce is high in exactly those TCK cycles where the controller is in Shift-DR with the start instruction, so that each rising edge in that state is one start-up step. It is low elsewhere, including Shift-DR under the load instruction.
- R9: scan_mode_sel is high only for mode values 3'b101 and 3'b001 (order M2,M1,M0). Loading words works for any mode value.
- R10: TDO and tdo_oe change on falling TCK. tdo_oe is high only during Shift-IR and Shift-DR, and TDO is 0 while tdo_oe is low. After a rising edge, TDO keeps the value set on the falling edge before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| mode_pins | input | 3 | Mode pins {M2,M1,M0} |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | TDO drive enable |
| cfg_word | output | 32 | Last completed configuration word |
| cfg_word_valid | output | 1 | One-TCK strobe for a new word |
| startup_ce | output | 1 | Start-up sequencer clock enable |
| scan_mode_sel | output | 1 | Boundary-scan configuration mode selected |

## Verification
The assertions assume that TMS is driven to a known level from time zero, because the five-ones property looks four edges back at TMS. They also assume that TMS and TDI are settled around each rising TCK, and that TRST_n is released while TCK is low. The bench drives TMS and TDI only a short time after a falling edge. It holds TMS high and TRST_n low from the start, and it moves TRST_n only in the low phase of TCK. It samples TDO just after the falling edge, so each sample matches the bit that the following rising edge shifts.

// File: rtl/cfg_tap_pkg.sv
package cfg_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  localparam int IR_W = 5;
  localparam logic [IR_W-1:0] OP_BYPASS = 5'b11111;
  localparam logic [IR_W-1:0] OP_IDCODE = 5'b01001;
  localparam logic [IR_W-1:0] OP_LOAD   = 5'b00101;
  localparam logic [IR_W-1:0] OP_START  = 5'b01100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SHF_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  // {M2,M1,M0} = 101 or 001 picks boundary-scan configuration
  function automatic logic scan_mode(input logic [2:0] mp);
    return (mp[1:0] == 2'b01);
  endfunction

endpackage

// File: rtl/cfg_tap_fsm.sv
module cfg_tap_fsm
  import cfg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= tap_next(state, tms);
  end

  // R1
  tms_five_ones_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == ST_TLR));

endmodule

// File: rtl/cfg_tap_ir.sv
module cfg_tap_ir
  import cfg_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_out
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
      ir_q  <= OP_IDCODE;
    end else begin
      case (state)
        ST_CAP_IR: ir_sr <= IR_CAPTURE;
        ST_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        default:   ir_sr <= ir_sr;
      endcase
      if (state == ST_UPD_IR)   ir_q <= ir_sr;
      else if (state == ST_TLR) ir_q <= OP_IDCODE;
    end
  end

  assign ir_out = ir_sr[0];

  // R2
  ir_update_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir_q) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR));

endmodule

// File: rtl/cfg_tap_packer.sv
module cfg_tap_packer #(
  parameter int WORD_W = 32
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              restart,
  input  logic              shift_en,
  input  logic              tdi,
  output logic [WORD_W-1:0] word,
  output logic              word_valid
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;
  logic              word_done;

  assign word_done = shift_en && (cnt == LAST);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      acc        <= '0;
      cnt        <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= word_done;
      if (restart) begin
        cnt <= '0;
      end else if (shift_en) begin
        acc <= {acc[WORD_W-2:0], tdi};
        cnt <= word_done ? '0 : cnt + 1'b1;
      end
      if (word_done) word <= {acc[WORD_W-2:0], tdi};
    end
  end

  // R5
  valid_one_cycle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    word_valid |=> !word_valid);

  // R7
  valid_from_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    word_valid |-> $past(shift_en));

endmodule

// File: rtl/cfg_tap_port.sv
module cfg_tap_port
  import cfg_tap_pkg::*;
#(
  parameter int          WORD_W  = 32,
  parameter logic [31:0] ID_CODE = 32'h1A5C_E093
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [2:0]        mode_pins,
  output logic              tdo,
  output logic              tdo_oe,
  output logic [WORD_W-1:0] cfg_word,
  output logic              cfg_word_valid,
  output logic              startup_ce,
  output logic              scan_mode_sel
);

  tap_state_t      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_out;
  logic [31:0]     id_sr;
  logic            byp_q;
  logic            dr_out;
  logic            in_shift_dr, in_shift_ir;
  logic            load_shift;

  cfg_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  cfg_tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .ir_q(ir_q), .ir_out(ir_out)
  );

  assign in_shift_dr = (state == ST_SHF_DR);
  assign in_shift_ir = (state == ST_SHF_IR);
  assign load_shift  = in_shift_dr && (ir_q == OP_LOAD);

  cfg_tap_packer #(.WORD_W(WORD_W)) u_pack (
    .tck(tck), .trst_n(trst_n), .restart(state == ST_CAP_DR),
    .shift_en(load_shift), .tdi(tdi),
    .word(cfg_word), .word_valid(cfg_word_valid)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= '0;
      byp_q <= 1'b0;
    end else begin
      if (state == ST_CAP_DR) begin
        id_sr <= ID_CODE;
        byp_q <= 1'b0;
      end else if (in_shift_dr) begin
        id_sr <= {tdi, id_sr[31:1]};
        byp_q <= tdi;
      end
    end
  end

  assign dr_out = (ir_q == OP_IDCODE) ? id_sr[0] : byp_q;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift_dr || in_shift_ir;
      tdo    <= in_shift_ir ? ir_out : (in_shift_dr ? dr_out : 1'b0);
    end
  end

  assign startup_ce    = in_shift_dr && (ir_q == OP_START);
  assign scan_mode_sel = scan_mode(mode_pins);

  // R8
  ce_enters_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(startup_ce) |-> ($past(state) == ST_CAP_DR || $past(state) == ST_EX2_DR));

  // R10
  tdo_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> !tdo);

  // R9
  scan_mode_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
    scan_mode_sel |-> (mode_pins[1] == 1'b0 && mode_pins[0] == 1'b1));

endmodule

// File: tb/test_cfg_tap_port.sv
module test_cfg_tap_port;

  localparam logic [31:0] ID = 32'h1A5C_E093;
  localparam logic [4:0] C_BYP = 5'b11111, C_ID = 5'b01001, C_LOAD = 5'b00101, C_START = 5'b01100;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [2:0] mode_pins = 3'b101;
  logic tdo, tdo_oe, cfg_word_valid, startup_ce, scan_mode_sel;
  logic [31:0] cfg_word;

  int n_chk = 0, n_bad = 0, valid_cnt = 0, got_n = 0;
  logic s_tdo, s_oe, s_ce;
  logic [31:0] got_word [4];
  int got_at [4];
  logic [63:0] sh_out;
  bit done = 0;

  cfg_tap_port i_cfg_tap_port (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .mode_pins(mode_pins),
    .tdo(tdo), .tdo_oe(tdo_oe), .cfg_word(cfg_word), .cfg_word_valid(cfg_word_valid),
    .startup_ce(startup_ce), .scan_mode_sel(scan_mode_sel)
  );

  always #4 tck = ~tck;

  always @(negedge tck) if (cfg_word_valid) valid_cnt++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); #2;
    s_tdo = tdo; s_oe = tdo_oe; s_ce = startup_ce;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic goto_rti();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [4:0] op, output logic [4:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, op[i]);
      cap[i] = s_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  // shifts n bits of data (bit 0 first); records TDO and any word strobes
  task automatic shift_dr(input int n, input logic [63:0] data);
    got_n = 0;
    sh_out = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, data[i]);
      sh_out[i] = s_tdo;
      if (cfg_word_valid && got_n < 4) begin
        got_word[got_n] = cfg_word;
        got_at[got_n] = i;
        got_n++;
      end
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [63:0] msb_stream(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r;
    for (int i = 0; i < 32; i++) begin
      r[i] = a[31 - i];
      r[32 + i] = b[31 - i];
    end
    return r;
  endfunction

  task automatic t_reset();
    logic [4:0] c;
    #1;
    chk(tdo_oe == 0 && tdo == 0, "R10 reset tdo", {tdo_oe, tdo}, 0);
    chk(cfg_word_valid == 0 && startup_ce == 0, "R8 reset strobes", {cfg_word_valid, startup_ce}, 0);
    @(negedge tck); #1 trst_n = 1'b1;
    goto_rti();
    chk(s_oe == 0, "R10 oe low outside shift", s_oe, 0);
    shift_dr(32, 64'h0);
    chk(sh_out[31:0] == ID, "R3 idcode after reset (R2 default IDCODE)", sh_out[31:0], ID);
    load_ir(C_ID, c);
    chk(c == 5'b00001, "R2 IR capture pattern", c, 5'b00001);
  endtask

  task automatic t_bypass();
    logic [4:0] c;
    logic [63:0] d = 64'hC3A5_0F96_5AA5_3C71;
    int v0;
    bit tdo_hold = 1;
    load_ir(C_BYP, c);
    v0 = valid_cnt;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 40; i++) begin
      step(i == 39, d[i]);
      sh_out[i] = s_tdo;
      if (i == 5) chk(s_oe == 1, "R10 oe high in shift", s_oe, 1);
      if (tdo != s_tdo) tdo_hold = 0;
    end
    step(1, 0); step(0, 0);
    chk(tdo_hold, "R10 tdo stable across rising edge", tdo_hold, 1);
    chk(sh_out[0] == 0, "R4 bypass captures 0", sh_out[0], 0);
    chk(sh_out[39:1] == d[38:0], "R4 bypass one-bit delay", sh_out[39:1], d[38:0]);
    chk(valid_cnt == v0, "R7 no word under bypass", valid_cnt - v0, 0);
  endtask

  task automatic t_tms_reset();
    logic [4:0] c;
    load_ir(C_BYP, c);
    step(1, 0); step(0, 0);      // park in Capture-DR
    goto_rti();                  // five TMS-high edges then RTI
    shift_dr(32, 64'h0);
    chk(sh_out[31:0] == ID, "R1 five TMS high resets, R2 IR back to IDCODE", sh_out[31:0], ID);
  endtask

  task automatic t_trst();
    logic [4:0] c;
    load_ir(C_BYP, c);
    step(1, 0); step(0, 0); step(0, 0);   // in Shift-DR
    @(negedge tck); #3 trst_n = 1'b0;
    #1 chk(tdo_oe == 0, "R1 TRST_n async, oe drops", tdo_oe, 0);
    @(negedge tck); #1 trst_n = 1'b1; tms = 1'b1;
    goto_rti();
    shift_dr(32, 64'h0);
    chk(sh_out[31:0] == ID, "R1 TRST_n returns IR to IDCODE", sh_out[31:0], ID);
  endtask

  task automatic t_load();
    logic [4:0] c;
    logic [31:0] w0 = 32'hDEAD_8001, w1 = 32'h0137_C5FE;
    int v0;
    bit ce_seen = 0;
    mode_pins = 3'b000;
    load_ir(C_LOAD, c);
    v0 = valid_cnt;
    shift_dr(64, msb_stream(w0, w1));
    chk(got_n == 2, "R5 two words from 64 bits (R9 any mode)", got_n, 2);
    chk(got_at[0] == 31 && got_word[0] == w0, "R5 first word MSB first", got_word[0], w0);
    chk(got_at[1] == 63 && got_word[1] == w1, "R5 second word", got_word[1], w1);
    chk(valid_cnt - v0 == 2, "R5 strobe one TCK per word", valid_cnt - v0, 2);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, 1'b1);
      if (s_ce) ce_seen = 1;
    end
    step(1, 0); step(0, 0);
    chk(!ce_seen, "R8 no start-up step under load", ce_seen, 0);
    mode_pins = 3'b101;
  endtask

  task automatic t_partial();
    logic [4:0] c;
    logic [31:0] w = 32'h9E37_79B9;
    load_ir(C_LOAD, c);
    shift_dr(40, {24'h0, 8'hFF, msb_stream(32'h1234_5678, 32'h0)});
    chk(got_n == 1 && got_word[0] == 32'h1234_5678, "R6 only full word kept", got_word[0], 32'h1234_5678);
    shift_dr(32, msb_stream(w, 32'h0));
    chk(got_n == 1 && got_at[0] == 31, "R6 count restarts at capture", got_at[0], 31);
    chk(got_word[0] == w, "R6 fresh word", got_word[0], w);
  endtask

  task automatic t_start();
    logic [4:0] c;
    int ce_n = 0, v0;
    load_ir(C_START, c);
    v0 = valid_cnt;
    step(1, 0); step(0, 0); step(0, 0);
    chk(startup_ce == 1, "R8 ce high in Shift-DR under start", startup_ce, 1);
    for (int i = 0; i < 40; i++) begin
      step(i == 39, 1'b1);
      if (s_ce) ce_n++;
    end
    step(1, 0);
    chk(s_ce == 0, "R8 ce low in Exit1-DR", s_ce, 0);
    step(0, 0);
    chk(ce_n == 40, "R8 one step per TCK", ce_n, 40);
    chk(valid_cnt == v0, "R7 no word under start", valid_cnt - v0, 0);
  endtask

  task automatic t_mode();
    for (int m = 0; m < 8; m++) begin
      mode_pins = 3'(m);
      #1;
      chk(scan_mode_sel == (m == 5 || m == 1), "R9 mode decode", scan_mode_sel, (m == 5 || m == 1));
    end
    mode_pins = 3'b101;
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_tms_reset();
    t_trst();
    t_load();
    t_partial();
    t_start();
    t_mode();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule